// File: doc/BRIEF.md
# Multi-Source Reset Controller

The block merges seven reset requests into one synchronous system reset, `sys_rst_o`. The sources are a supply-low flag, a watchdog expiry flag, a missing-clock flag, a comparator trip flag, a software reset strobe, a convert-start pin and an external reset pin. The supply and the external pin cannot be masked by software. The supply source is gated only by the `mon_en_i` pin. Each of the other five has an enable bit in a small control register.

A supply request keeps the reset asserted for a long stretch after the flag clears. Every other request keeps it asserted for a short minimum hold. The combined reset is driven back out on the external pin as an open-drain pull-down. The block ignores its own drive when it samples that pin. When a reset is released, a cause register records which sources requested it. Any reset puts the control register back to its defaults. This returns the clock selection to the internal oscillator.

The watchdog enable can be locked on. The lock survives every reset except power-on.

Top module: `rst_hub`

## Requirements
- R1: `cause_o` uses this bit order: 0 supply, 1 watchdog, 2 missing clock, 3 comparator, 4 software, 5 convert-start, 6 external pin. When a reset is released, `cause_o` is loaded with the set of sources that requested it, and it holds that value until the next release.
- R2: The maskable sources have their enables in `cfg_rdata_o`: bit 0 watchdog, bit 1 missing clock, bit 2 comparator, bit 3 convert-start, bit 4 software. A request from a source whose bit is clear has no effect on `sys_rst_o` or `cause_o`.
- R3: The supply request is `mon_en_i & supply_low_i`. It is independent of `cfg_rdata_o`, and it is ignored while `mon_en_i` is low.
- R4: Writing bit 5 (lock) of the control register forces bit 0 to 1. Both bits then stay set through writes and system resets. Only `rst_ni` clears them.
- R5: `rst_pin_oe_o` pulls the external pin low exactly while `sys_rst_o` is high. The pin value that results from this drive does not start or extend a reset.
- R6: `sys_rst_o` stays high for exactly 16 cycles after the last clock edge at which the supply request was sampled high. After `rst_ni` rises, it stays high for 16 cycles.
- R7: A one-cycle request from any non-supply source holds `sys_rst_o` high for exactly 5 cycles, which is the 4-cycle minimum plus the request cycle.
- R8: The external pin (active low) and the convert-start pin (active high) pass through two synchronizer flops. `sys_rst_o` rises at the third clock edge after the pin changes.
- R9: Bit 6 of the control register drives `clk_sel_o` (1 = external clock). While `sys_rst_o` is high, the control register returns to its default value of 0x01, with the lock bit kept, and writes are dropped.
- R10: `rst_ni` low forces `sys_rst_o` and `rst_pin_oe_o` high, and sets `cause_o` and `cfg_rdata_o` to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| mon_en_i | input | 1 | Supply monitor enable pin |
| supply_low_i | input | 1 | Supply-low flag |
| wdt_expire_i | input | 1 | Watchdog expiry flag |
| clk_missing_i | input | 1 | Missing-clock detector flag |
| cmp_trip_i | input | 1 | Comparator level trip flag |
| sw_rst_i | input | 1 | Software reset write strobe |
| cnv_pin_i | input | 1 | Convert-start pin, asynchronous, active high |
| rst_pin_i | input | 1 | External reset pin value, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 7 | Control register write data |
| cfg_rdata_o | output | 7 | Control register contents |
| cause_o | output | 7 | Reset cause flags |
| sys_rst_o | output | 1 | Synchronous system reset, active high |
| rst_pin_oe_o | output | 1 | Pull-down enable for the external reset pin |
| clk_sel_o | output | 1 | Clock select, 0 = internal oscillator |

## Verification
The bench sweeps each maskable source with its enable both set and clear. For each case it counts the exact number of reset cycles and checks the cause bit. A wrong bit mapping or a missing gate would therefore show up as a wrong count or a wrong cause. The pin is modelled as a wired-OR that includes the block's own pull-down. A design that took back its own drive would lengthen every reset, and a design with the wrong synchronizer depth would raise the reset one edge early or late. The watchdog lock is checked across a software reset and a power-on. A lock that cleared on a system reset, or that survived power-on, would show in the register readback. Supply stretch lengths, the merging of simultaneous causes, and writes dropped during reset are also checked.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned CFG_W   = 7;

  typedef enum logic [2:0] {
    SRC_SUPPLY = 3'd0,
    SRC_WDT    = 3'd1,
    SRC_MCD    = 3'd2,
    SRC_CMP    = 3'd3,
    SRC_SW     = 3'd4,
    SRC_CNV    = 3'd5,
    SRC_PIN    = 3'd6
  } src_e;

  // packed MSB first: wdt_en lands on bit 0
  typedef struct packed {
    logic clk_ext;
    logic wdt_lock;
    logic sw_en;
    logic cnv_en;
    logic cmp_en;
    logic mcd_en;
    logic wdt_en;
  } cfg_t;

  localparam cfg_t CFG_RST = '{wdt_en: 1'b1, default: 1'b0};
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned HOLD       = 4,
  parameter bit          START_HELD = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic hold_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= START_HELD ? LOAD : '0;
    else if (req_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = req_i | (cnt_q != '0);
endmodule

// File: rtl/rst_cfg.sv
module rst_cfg
  import rst_hub_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic we_i,
  input  cfg_t wdata_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (clr_i) begin
      cfg_d          = CFG_RST;
      cfg_d.wdt_lock = cfg_q.wdt_lock;
    end else if (we_i) begin
      cfg_d          = wdata_i;
      cfg_d.wdt_lock = cfg_q.wdt_lock | wdata_i.wdt_lock;
      cfg_d.wdt_en   = wdata_i.wdt_en | cfg_d.wdt_lock;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_RST;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/rst_hub.sv
module rst_hub
  import rst_hub_pkg::*;
#(
  parameter int unsigned SUP_HOLD    = 16,
  parameter int unsigned MIN_HOLD    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mon_en_i,
  input  logic             supply_low_i,
  input  logic             wdt_expire_i,
  input  logic             clk_missing_i,
  input  logic             cmp_trip_i,
  input  logic             sw_rst_i,
  input  logic             cnv_pin_i,
  input  logic             rst_pin_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic [NUM_SRC-1:0] cause_o,
  output logic             sys_rst_o,
  output logic             rst_pin_oe_o,
  output logic             clk_sel_o
);
  logic sys_rst_q, sys_rst_d;
  logic cnv_s, pin_s, own_drive;
  logic sup_hold, oth_hold;
  logic [SYNC_STAGES-1:0] oe_hist_q;
  logic [NUM_SRC-1:0] req_vec, pend_q, cause_q;
  cfg_t cfg;

  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cnv_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cnv_pin_i), .q_o(cnv_s));

  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rst_pin_i), .q_o(pin_s));

  rst_cfg u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(sys_rst_q),
    .we_i(cfg_we_i), .wdata_i(cfg_t'(cfg_wdata_i)), .cfg_o(cfg));

  // mask the pin while our own pull-down may still be in the sync chain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_hist_q <= '1;
    else         oe_hist_q <= {oe_hist_q[SYNC_STAGES-2:0], sys_rst_q};
  end
  assign own_drive = sys_rst_q | (|oe_hist_q);

  always_comb begin
    req_vec             = '0;
    req_vec[SRC_SUPPLY] = mon_en_i & supply_low_i;
    req_vec[SRC_WDT]    = cfg.wdt_en & wdt_expire_i;
    req_vec[SRC_MCD]    = cfg.mcd_en & clk_missing_i;
    req_vec[SRC_CMP]    = cfg.cmp_en & cmp_trip_i;
    req_vec[SRC_SW]     = cfg.sw_en  & sw_rst_i;
    req_vec[SRC_CNV]    = cfg.cnv_en & cnv_s;
    req_vec[SRC_PIN]    = ~pin_s & ~own_drive;
  end

  rst_stretch #(.HOLD(SUP_HOLD), .START_HELD(1'b1)) u_sup_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_vec[SRC_SUPPLY]), .hold_o(sup_hold));

  rst_stretch #(.HOLD(MIN_HOLD), .START_HELD(1'b0)) u_oth_hold (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(|req_vec[NUM_SRC-1:1]), .hold_o(oth_hold));

  assign sys_rst_d = sup_hold | oth_hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sys_rst_q <= 1'b1;
      pend_q    <= NUM_SRC'(1);
      cause_q   <= NUM_SRC'(1);
    end else begin
      sys_rst_q <= sys_rst_d;
      if (sys_rst_q && !sys_rst_d) begin
        cause_q <= pend_q | req_vec;
        pend_q  <= '0;
      end else begin
        pend_q  <= pend_q | req_vec;
      end
    end
  end

  assign sys_rst_o    = sys_rst_q;
  assign rst_pin_oe_o = sys_rst_q;
  assign cause_o      = cause_q;
  assign cfg_rdata_o  = cfg;
  assign clk_sel_o    = cfg.clk_ext;
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mon_en_i,
  input logic       supply_low_i,
  input logic       sw_rst_i,
  input logic [6:0] cfg_rdata_o,
  input logic [6:0] cause_o,
  input logic       sys_rst_o,
  input logic       clk_sel_o,
  input logic [6:0] req_vec
);
  AST_SUP_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_en_i && supply_low_i) |=> sys_rst_o);  // R6
  AST_SW_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_i && cfg_rdata_o[4] && !sys_rst_o) |=> sys_rst_o);  // R7
  AST_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |=> sys_rst_o);  // R7
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[5] |=> (cfg_rdata_o[5] && cfg_rdata_o[0]));  // R4
  AST_CLK_INTERNAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !clk_sel_o);  // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(|req_vec));  // R2
  AST_CAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sys_rst_o) |-> $stable(cause_o));  // R1
endmodule

bind rst_hub rst_hub_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mon_en_i(mon_en_i),
  .supply_low_i(supply_low_i), .sw_rst_i(sw_rst_i),
  .cfg_rdata_o(cfg_rdata_o), .cause_o(cause_o), .sys_rst_o(sys_rst_o),
  .clk_sel_o(clk_sel_o), .req_vec(req_vec));

// File: tb/rst_hub_bench.sv
module rst_hub_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mon_en_i = 1'b0, supply_low_i = 1'b0, wdt_expire_i = 1'b0;
  logic clk_missing_i = 1'b0, cmp_trip_i = 1'b0, sw_rst_i = 1'b0;
  logic cnv_pin_i = 1'b0, ext_low = 1'b0, cfg_we_i = 1'b0;
  logic [6:0] cfg_wdata_i = '0;
  logic [6:0] cfg_rdata_o, cause_o;
  logic sys_rst_o, rst_pin_oe_o, clk_sel_o;
  wire  rst_pin = !(rst_pin_oe_o || ext_low);

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  rst_hub u_rst_hub (
    .clk_i(clk_i), .rst_ni(rst_ni), .mon_en_i(mon_en_i),
    .supply_low_i(supply_low_i), .wdt_expire_i(wdt_expire_i),
    .clk_missing_i(clk_missing_i), .cmp_trip_i(cmp_trip_i),
    .sw_rst_i(sw_rst_i), .cnv_pin_i(cnv_pin_i), .rst_pin_i(rst_pin),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .cause_o(cause_o), .sys_rst_o(sys_rst_o),
    .rst_pin_oe_o(rst_pin_oe_o), .clk_sel_o(clk_sel_o));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(logic [6:0] v);
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic count_tail(inout int n);
    repeat (40) begin
      @(negedge clk_i);
      if (sys_rst_o) n++;
    end
  endtask

  task automatic drive_src(int s, logic v);
    case (s)
      1: wdt_expire_i  = v;
      2: clk_missing_i = v;
      3: cmp_trip_i    = v;
      4: sw_rst_i      = v;
      5: cnv_pin_i     = v;
      6: ext_low       = v;
      default: supply_low_i = v;
    endcase
  endtask

  // one-cycle pulse, returns number of reset cycles seen
  task automatic pulse(int s, output int n);
    n = 0;
    @(negedge clk_i); drive_src(s, 1'b1);
    @(negedge clk_i); drive_src(s, 1'b0);
    if (sys_rst_o) n++;
    count_tail(n);
  endtask

  task automatic do_por();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R10 sys_rst in por", int'(sys_rst_o), 1);
    chk("R10 pin drive in por", int'(rst_pin_oe_o), 1);
    chk("R10 cause in por", int'(cause_o), 1);
    chk("R10 cfg in por", int'(cfg_rdata_o), 1);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    logic [6:0] prev;
    // power-on stretch
    repeat (2) @(negedge clk_i);
    chk("R10 sys_rst at reset", int'(sys_rst_o), 1);
    chk("R10 cause at reset", int'(cause_o), 1);
    rst_ni = 1'b1;
    n = 0; count_tail(n);
    chk("R6 por stretch cycles", n, 16);
    chk("R10 cause after por", int'(cause_o), 1);
    chk("R9 cfg default", int'(cfg_rdata_o), 1);
    chk("R9 clk internal", int'(clk_sel_o), 0);

    // maskable sources, enabled and disabled
    for (int s = 1; s <= 5; s++) begin
      for (int en = 0; en < 2; en++) begin
        int bitpos;
        bitpos = (s == 1) ? 0 : (s == 2) ? 1 : (s == 3) ? 2 : (s == 4) ? 4 : 3;
        wr_cfg(en != 0 ? 7'(1 << bitpos) : 7'h00);
        prev = cause_o;
        pulse(s, n);
        chk($sformatf("R2 R7 src%0d en%0d cycles", s, en), n, en != 0 ? 5 : 0);
        chk($sformatf("R1 R2 src%0d en%0d cause", s, en), int'(cause_o),
            en != 0 ? (1 << s) : int'(prev));
      end
    end

    // R8 external pin latency, R5 own drive not fed back
    @(negedge clk_i); ext_low = 1'b1;
    @(negedge clk_i); ext_low = 1'b0;
    chk("R8 pin edge 1", int'(sys_rst_o), 0);
    @(negedge clk_i);
    chk("R8 pin edge 2", int'(sys_rst_o), 0);
    @(negedge clk_i);
    chk("R8 pin edge 3", int'(sys_rst_o), 1);
    chk("R5 pin drive follows", int'(rst_pin_oe_o), 1);
    n = 1; count_tail(n);
    chk("R5 R7 pin reset cycles", n, 5);
    chk("R1 pin cause", int'(cause_o), 7'h40);

    wr_cfg(7'h10);
    pulse(4, n);
    chk("R5 own drive no retrigger", n, 5);
    chk("R5 cause without pin bit", int'(cause_o), 7'h10);

    // R8 convert-start latency
    wr_cfg(7'h08);
    @(negedge clk_i); cnv_pin_i = 1'b1;
    @(negedge clk_i); cnv_pin_i = 1'b0;
    @(negedge clk_i);
    chk("R8 cnv edge 2", int'(sys_rst_o), 0);
    @(negedge clk_i);
    chk("R8 cnv edge 3", int'(sys_rst_o), 1);
    n = 1; count_tail(n);

    // R3 supply: masked by pin only
    wr_cfg(7'h00);
    mon_en_i = 1'b0;
    prev = cause_o;
    pulse(0, n);
    chk("R3 monitor off cycles", n, 0);
    chk("R3 monitor off cause", int'(cause_o), int'(prev));
    mon_en_i = 1'b1;
    wr_cfg(7'h00);
    n = 0;
    @(negedge clk_i); supply_low_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (sys_rst_o) n++;
    end
    supply_low_i = 1'b0;
    count_tail(n);
    chk("R6 R3 supply stretch cycles", n, 19);
    chk("R1 supply cause", int'(cause_o), 1);
    mon_en_i = 1'b0;

    // R1 merged causes
    wr_cfg(7'h14);
    @(negedge clk_i); cmp_trip_i = 1'b1; sw_rst_i = 1'b1;
    @(negedge clk_i); cmp_trip_i = 1'b0; sw_rst_i = 1'b0;
    n = 1; count_tail(n);
    chk("R7 merged cycles", n, 5);
    chk("R1 merged cause", int'(cause_o), 7'h18);

    // R9 clock select and writes dropped in reset
    wr_cfg(7'h50);
    chk("R9 clk external", int'(clk_sel_o), 1);
    @(negedge clk_i); sw_rst_i = 1'b1;
    @(negedge clk_i); sw_rst_i = 1'b0;
    @(negedge clk_i); cfg_we_i = 1'b1; cfg_wdata_i = 7'h46;
    @(negedge clk_i); cfg_we_i = 1'b0;
    chk("R9 clk internal in reset", int'(clk_sel_o), 0);
    n = 0; count_tail(n);
    chk("R9 write dropped cfg", int'(cfg_rdata_o), 1);
    chk("R9 clk internal after", int'(clk_sel_o), 0);

    // R4 watchdog lock
    wr_cfg(7'h30);
    chk("R4 lock forces wdt", int'(cfg_rdata_o), 7'h31);
    wr_cfg(7'h10);
    chk("R4 lock write ignored", int'(cfg_rdata_o), 7'h31);
    pulse(4, n);
    chk("R4 sw reset cycles", n, 5);
    chk("R4 lock survives reset", int'(cfg_rdata_o), 7'h21);
    pulse(1, n);
    chk("R4 wdt fires locked", n, 5);
    chk("R4 wdt cause", int'(cause_o), 7'h02);
    do_por();
    n = 0; count_tail(n);
    chk("R6 por stretch again", n, 16);
    chk("R4 lock cleared by por", int'(cfg_rdata_o), 1);
    wr_cfg(7'h00);
    chk("R4 wdt clearable after por", int'(cfg_rdata_o), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule